// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

This block sits between the interrupt message fabric and a processor core. It records every vector delivered to the core and tracks which of them are waiting and which are being serviced. From these it decides whether the core may be interrupted. There are 256 vectors, and each has three state bits: a request bit (the vector is waiting), an in-service bit (the core has taken it and not yet retired it) and a trigger bit (it arrived level-triggered). Vectors 0 to 15 are reserved and are never recorded.

A higher vector number means a higher priority, and the upper four bits of a vector are its priority class. Software writes an 8-bit task priority. The block combines that value with the highest in-service vector to form the processor priority. The highest waiting vector is offered to the core only when its class is strictly above the class of the processor priority. When the core acknowledges, the offered vector moves from waiting to in service. When the core signals end of interrupt, the highest in-service vector is retired. If that vector was level-triggered, a one-cycle broadcast carries its number out to the interrupt sources so they can re-arm.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A synchronous active-low reset clears all request, in-service and trigger bits and the task priority. After reset `proc_prio` is 0x00, `irq_present` is 0, `ack_vec` equals `spur_vec`, and `eoi_bcast_valid` is 0.
- R2: An accept pulse for a vector of 16 or above sets that vector's request bit on the next clock edge. An accept for a vector from 0 to 15 changes no state.
- R3: `irq_present` is 1 exactly when a request bit is set and the class (bits 7:4) of the highest waiting vector is strictly greater than `proc_prio[7:4]`. A task priority with class 15 therefore blocks every vector.
- R4: `proc_prio` equals the task priority when task[7:4] >= S[7:4]. Otherwise it equals {S[7:4], 4'b0000}. S is the highest set in-service vector, or 0 when no in-service bit is set.
- R5: While `irq_present` is 1, `ack_vec` shows the highest waiting vector. An acknowledge in that state clears that vector's request bit and sets its in-service bit.
- R6: While `irq_present` is 0, `ack_vec` shows `spur_vec`, and an acknowledge changes no state.
- R7: Each accepted vector's trigger bit is loaded from `acc_level` (1 = level, 0 = edge), so a later edge accept of the same vector clears a previously set trigger bit.
- R8: An end-of-interrupt strobe clears only the highest set in-service bit. The next waiting vector is then judged against the lowered priority. With no in-service bit set, the strobe has no effect.
- R9: When the retired vector's trigger bit is 1, `eoi_bcast_valid` is 1 for exactly the one cycle after the strobe edge, and `eoi_bcast_vec` carries the retired vector. An edge-triggered retirement gives no pulse.
- R10: An accept for a vector whose request bit is already set merges into the existing request, so a single acknowledge consumes it.
- R11: A blocked request stays recorded and is offered as soon as a task-priority write or a retirement lowers the processor priority below its class.
- R12: Among several waiting vectors, the one with the highest number is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Accept pulse for a delivered vector |
| acc_vec | input | 8 | Vector being accepted |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_strobe | input | 1 | Core acknowledge |
| eoi_strobe | input | 1 | End-of-interrupt write |
| tpr_we | input | 1 | Task priority write enable |
| tpr_wdata | input | 8 | Task priority write value |
| spur_vec | input | 8 | Vector returned when nothing can be offered |
| irq_present | output | 1 | A vector may interrupt the core |
| ack_vec | output | 8 | Vector returned on acknowledge |
| proc_prio | output | 8 | Computed processor priority |
| eoi_bcast_valid | output | 1 | One-cycle broadcast of a level EOI |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |

## Verification
The bench targets class comparisons at the boundary. It checks a waiting vector whose class equals the priority class, which a design using >= instead of > would wrongly offer. It sets the task class to 15, and a design that mishandles this lets a vector through. It uses an in-service vector above the task class to catch a processor priority that never folds in service state. A vector that is accepted as level and then re-accepted as edge, before it is retired, catches a trigger bit that only ever sets: such a design would broadcast a spurious EOI. An acknowledge with nothing offerable, an EOI with an empty in-service set, and accepts into the reserved range check designs that would corrupt state or return a live vector in place of the spurious one.

// File: rtl/irq_accept_pkg.sv
// Shared widths and helpers for the interrupt acceptance controller.
// Assumes a power-of-two vector space split into equal priority classes.
package irq_accept_pkg;
    localparam int NUM_VEC  = 256;
    localparam int VEC_W    = $clog2(NUM_VEC);
    localparam int CLS_W    = 4;
    localparam int SUB_W    = VEC_W - CLS_W;
    localparam int RSVD_VEC = 16;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CLS_W-1:0] cls_t;

    // Priority class of a vector: its upper bits.
    function automatic cls_t class_of(input vec_t v);
        return v[VEC_W-1:SUB_W];
    endfunction
endpackage

// File: rtl/irq_prio_enc.sv
// Highest-set-bit encoder over a parameterized bit-vector.
// Assumes index 0 is the lowest priority; any_o is 0 and idx_o is 0 when empty.
module irq_prio_enc #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    // Scan upward so the last set bit found is the highest.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (bits_i[i]) begin
                idx_o = IW'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_vec_store.sv
// Per-vector request, in-service and trigger state.
// Assumes the caller qualifies accepts (non-reserved), takes (offerable) and
// retires (in-service non-empty); reserved vectors hold constant zero.
module irq_vec_store
    import irq_accept_pkg::*;
#(
    parameter int N    = NUM_VEC,
    parameter int RSVD = RSVD_VEC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_ok,
    input  vec_t         acc_vec,
    input  logic         acc_level,
    input  logic         take,
    input  vec_t         take_vec,
    input  logic         retire,
    input  vec_t         retire_vec,
    output logic [N-1:0] irr_q,
    output logic [N-1:0] isr_q,
    output logic [N-1:0] tmr_q
);
    for (genvar g = 0; g < N; g++) begin : g_vec
        if (g < RSVD) begin : g_rsvd
            assign irr_q[g] = 1'b0;
            assign isr_q[g] = 1'b0;
            assign tmr_q[g] = 1'b0;
        end else begin : g_live
            logic acc_hit, take_hit, ret_hit;
            assign acc_hit  = acc_ok && (acc_vec == vec_t'(g));
            assign take_hit = take   && (take_vec == vec_t'(g));
            assign ret_hit  = retire && (retire_vec == vec_t'(g));

            // Request bit: an accept sets it, a take clears it, an accept wins.
            always_ff @(posedge clk) begin
                if (!rst_n)        irr_q[g] <= 1'b0;
                else if (acc_hit)  irr_q[g] <= 1'b1;
                else if (take_hit) irr_q[g] <= 1'b0;
            end

            // In-service bit: a take sets it, a retirement clears it.
            always_ff @(posedge clk) begin
                if (!rst_n)        isr_q[g] <= 1'b0;
                else if (take_hit) isr_q[g] <= 1'b1;
                else if (ret_hit)  isr_q[g] <= 1'b0;
            end

            // Trigger bit: loaded from the level flag on every accept.
            always_ff @(posedge clk) begin
                if (!rst_n)       tmr_q[g] <= 1'b0;
                else if (acc_hit) tmr_q[g] <= acc_level;
            end
        end
    end

    p_rsvd_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irr_q[RSVD-1:0] == '0) && (isr_q[RSVD-1:0] == '0));

    p_take_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(acc_ok && acc_vec == take_vec))
        |=> (!irr_q[$past(take_vec)] && isr_q[$past(take_vec)]));
endmodule

// File: rtl/irq_prio_calc.sv
// Task priority register, processor priority and the presentation gate.
// Assumes the class inputs come from highest-set-bit encoders.
module irq_prio_calc
    import irq_accept_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tpr_we,
    input  vec_t tpr_wdata,
    input  cls_t isr_cls,
    input  logic irr_any,
    input  cls_t irr_cls,
    output vec_t ppr,
    output logic present
);
    vec_t tpr_q;

    // Task priority register, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)      tpr_q <= '0;
        else if (tpr_we) tpr_q <= tpr_wdata;
    end

    // Processor priority: task value unless in-service class is higher.
    always_comb begin
        if (class_of(tpr_q) >= isr_cls) ppr = tpr_q;
        else                            ppr = {isr_cls, {SUB_W{1'b0}}};
    end

    // Offer only a class strictly above the processor class.
    assign present = irr_any && (irr_cls > class_of(ppr));

    p_ppr_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ppr >= tpr_q) && (class_of(ppr) >= isr_cls));

    p_full_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (class_of(tpr_q) == {CLS_W{1'b1}}) |-> !present);
endmodule

// File: rtl/irq_accept_ctrl.sv
// Top of the interrupt acceptance controller: wires state, encoders and
// priority logic, and generates the level EOI broadcast.
// Assumes one core; strobes are single-cycle and sampled on the rising edge.
module irq_accept_ctrl
    import irq_accept_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic [7:0] acc_vec,
    input  logic       acc_level,
    input  logic       ack_strobe,
    input  logic       eoi_strobe,
    input  logic       tpr_we,
    input  logic [7:0] tpr_wdata,
    input  logic [7:0] spur_vec,
    output logic       irq_present,
    output logic [7:0] ack_vec,
    output logic [7:0] proc_prio,
    output logic       eoi_bcast_valid,
    output logic [7:0] eoi_bcast_vec
);
    logic [NUM_VEC-1:0] irr, isr, tmr;
    vec_t irr_top, isr_top;
    logic irr_any, isr_any;
    logic acc_ok, take, retire;

    assign acc_ok = acc_valid && (acc_vec >= vec_t'(RSVD_VEC));
    assign take   = ack_strobe && irq_present;
    assign retire = eoi_strobe && isr_any;

    irq_vec_store u_store (
        .clk(clk), .rst_n(rst_n),
        .acc_ok(acc_ok), .acc_vec(acc_vec), .acc_level(acc_level),
        .take(take), .take_vec(irr_top),
        .retire(retire), .retire_vec(isr_top),
        .irr_q(irr), .isr_q(isr), .tmr_q(tmr)
    );

    irq_prio_enc #(.N(NUM_VEC)) u_irr_enc (.bits_i(irr), .idx_o(irr_top), .any_o(irr_any));
    irq_prio_enc #(.N(NUM_VEC)) u_isr_enc (.bits_i(isr), .idx_o(isr_top), .any_o(isr_any));

    irq_prio_calc u_prio (
        .clk(clk), .rst_n(rst_n),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .isr_cls(class_of(isr_top)),
        .irr_any(irr_any), .irr_cls(class_of(irr_top)),
        .ppr(proc_prio), .present(irq_present)
    );

    // Acknowledge data: offered vector or the spurious one.
    assign ack_vec = irq_present ? irr_top : spur_vec;

    // One-cycle broadcast when a level-triggered vector retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bcast_valid <= 1'b0;
            eoi_bcast_vec   <= '0;
        end else begin
            eoi_bcast_valid <= retire && tmr[isr_top];
            if (retire) eoi_bcast_vec <= isr_top;
        end
    end

    p_bcast_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast_valid |-> $past(eoi_strobe));

    p_spur_nochange_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_strobe && !irq_present && !acc_valid && !eoi_strobe)
        |=> ($stable(irr) && $stable(isr)));

    p_eoi_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_strobe && isr_any && !ack_strobe)
        |=> ($countones(isr) + 1 == $countones($past(isr))));
endmodule

// File: tb/irq_accept_ctrl_bench.sv
// Table-driven bench followed by directed corner tests.
module irq_accept_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_level = 1'b0, ack_strobe = 1'b0;
    logic eoi_strobe = 1'b0, tpr_we = 1'b0;
    logic [7:0] acc_vec = '0, tpr_wdata = '0;
    logic [7:0] spur_vec = 8'h0F;
    logic irq_present, eoi_bcast_valid;
    logic [7:0] ack_vec, proc_prio, eoi_bcast_vec;
    int n_cmp = 0, n_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    irq_accept_ctrl u_irq_accept_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vec(acc_vec),
        .acc_level(acc_level), .ack_strobe(ack_strobe), .eoi_strobe(eoi_strobe),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .spur_vec(spur_vec),
        .irq_present(irq_present), .ack_vec(ack_vec), .proc_prio(proc_prio),
        .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vec(eoi_bcast_vec)
    );

    localparam logic [1:0] OP_ACC = 2'd0, OP_ACK = 2'd1, OP_EOI = 2'd2, OP_TPR = 2'd3;

    // {tag, op, data, lvl, ret, present, top, ppr, bcast, bvec}
    localparam int NT = 22;
    localparam logic [48:0] TBL [NT] = '{
        {4'd2,  OP_ACC, 8'h35, 1'b0, 8'h00, 1'b1, 8'h35, 8'h00, 1'b0, 8'h00}, // R2
        {4'd7,  OP_ACC, 8'h72, 1'b1, 8'h00, 1'b1, 8'h72, 8'h00, 1'b0, 8'h00}, // R7 R12
        {4'd2,  OP_ACC, 8'h08, 1'b0, 8'h00, 1'b1, 8'h72, 8'h00, 1'b0, 8'h00}, // R2 reserved
        {4'd3,  OP_TPR, 8'h75, 1'b0, 8'h00, 1'b0, 8'h0F, 8'h75, 1'b0, 8'h00}, // R3 equal class
        {4'd11, OP_TPR, 8'h20, 1'b0, 8'h00, 1'b1, 8'h72, 8'h20, 1'b0, 8'h00}, // R11
        {4'd5,  OP_ACK, 8'h00, 1'b0, 8'h72, 1'b0, 8'h0F, 8'h70, 1'b0, 8'h00}, // R5 R4
        {4'd12, OP_ACC, 8'h91, 1'b0, 8'h00, 1'b1, 8'h91, 8'h70, 1'b0, 8'h00}, // R12
        {4'd5,  OP_ACK, 8'h00, 1'b0, 8'h91, 1'b0, 8'h0F, 8'h90, 1'b0, 8'h00}, // R5
        {4'd8,  OP_EOI, 8'h00, 1'b0, 8'h00, 1'b0, 8'h0F, 8'h70, 1'b0, 8'h00}, // R8
        {4'd9,  OP_EOI, 8'h00, 1'b0, 8'h00, 1'b1, 8'h35, 8'h20, 1'b1, 8'h72}, // R9 R11
        {4'd5,  OP_ACK, 8'h00, 1'b0, 8'h35, 1'b0, 8'h0F, 8'h30, 1'b0, 8'h00}, // R5
        {4'd6,  OP_ACK, 8'h00, 1'b0, 8'h0F, 1'b0, 8'h0F, 8'h30, 1'b0, 8'h00}, // R6
        {4'd8,  OP_EOI, 8'h00, 1'b0, 8'h00, 1'b0, 8'h0F, 8'h20, 1'b0, 8'h00}, // R8
        {4'd7,  OP_ACC, 8'h50, 1'b1, 8'h00, 1'b1, 8'h50, 8'h20, 1'b0, 8'h00}, // R7
        {4'd10, OP_ACC, 8'h50, 1'b0, 8'h00, 1'b1, 8'h50, 8'h20, 1'b0, 8'h00}, // R10
        {4'd10, OP_ACK, 8'h00, 1'b0, 8'h50, 1'b0, 8'h0F, 8'h50, 1'b0, 8'h00}, // R10
        {4'd3,  OP_ACC, 8'h51, 1'b0, 8'h00, 1'b0, 8'h0F, 8'h50, 1'b0, 8'h00}, // R3
        {4'd3,  OP_TPR, 8'hF0, 1'b0, 8'h00, 1'b0, 8'h0F, 8'hF0, 1'b0, 8'h00}, // R3 class 15
        {4'd7,  OP_EOI, 8'h00, 1'b0, 8'h00, 1'b0, 8'h0F, 8'hF0, 1'b0, 8'h00}, // R7 cleared
        {4'd11, OP_TPR, 8'h00, 1'b0, 8'h00, 1'b1, 8'h51, 8'h00, 1'b0, 8'h00}, // R11
        {4'd5,  OP_ACK, 8'h00, 1'b0, 8'h51, 1'b0, 8'h0F, 8'h50, 1'b0, 8'h00}, // R5
        {4'd4,  OP_EOI, 8'h00, 1'b0, 8'h00, 1'b0, 8'h0F, 8'h00, 1'b0, 8'h00}  // R4
    };

    task automatic chk(input int tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one operation for one edge; ret holds ack_vec seen before the edge.
    task automatic do_op(input logic [1:0] op, input logic [7:0] d, input logic lvl, output logic [7:0] ret);
        @(negedge clk);
        acc_valid  = (op == OP_ACC);
        acc_vec    = d;
        acc_level  = lvl;
        ack_strobe = (op == OP_ACK);
        eoi_strobe = (op == OP_EOI);
        tpr_we     = (op == OP_TPR);
        tpr_wdata  = d;
        #1 ret = ack_vec;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 0; ack_strobe = 0; eoi_strobe = 0; tpr_we = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    initial begin
        logic [7:0] r;
        do_reset();
        // R1: reset state
        chk(1, "present", {7'd0, irq_present}, 8'h00);
        chk(1, "ppr", proc_prio, 8'h00);
        chk(1, "ackvec", ack_vec, 8'h0F);
        chk(1, "bcast", {7'd0, eoi_bcast_valid}, 8'h00);

        for (int i = 0; i < NT; i++) begin
            logic [48:0] e;
            e = TBL[i];
            do_op(e[44:43], e[42:35], e[34], r);
            if (e[44:43] == OP_ACK) chk(int'(e[48:45]), "ack return", r, e[33:26]);
            chk(int'(e[48:45]), "present", {7'd0, irq_present}, {7'd0, e[25]});
            chk(int'(e[48:45]), "ack_vec", ack_vec, e[24:17]);
            chk(int'(e[48:45]), "ppr", proc_prio, e[16:9]);
            chk(int'(e[48:45]), "bcast", {7'd0, eoi_bcast_valid}, {7'd0, e[8]});
            if (e[8]) chk(int'(e[48:45]), "bcast vec", eoi_bcast_vec, e[7:0]);
        end

        // R9: level retirement pulses exactly one cycle
        do_op(OP_ACC, 8'hE6, 1'b1, r);
        do_op(OP_ACK, 8'h00, 1'b0, r);
        chk(5, "ack return", r, 8'hE6);
        do_op(OP_EOI, 8'h00, 1'b0, r);
        chk(9, "bcast", {7'd0, eoi_bcast_valid}, 8'h01);
        chk(9, "bcast vec", eoi_bcast_vec, 8'hE6);
        @(negedge clk);
        chk(9, "bcast drop", {7'd0, eoi_bcast_valid}, 8'h00);

        // R8: EOI with empty in-service set does nothing
        do_op(OP_EOI, 8'h00, 1'b0, r);
        chk(8, "empty eoi bcast", {7'd0, eoi_bcast_valid}, 8'h00);
        chk(8, "empty eoi ppr", proc_prio, 8'h00);

        // R2: reserved vector does not present
        do_op(OP_ACC, 8'h0E, 1'b1, r);
        chk(2, "reserved present", {7'd0, irq_present}, 8'h00);

        // R1: reset mid-operation clears state
        do_op(OP_ACC, 8'h80, 1'b1, r);
        do_op(OP_TPR, 8'h30, 1'b0, r);
        do_reset();
        chk(1, "present after reset", {7'd0, irq_present}, 8'h00);
        chk(1, "ppr after reset", proc_prio, 8'h00);
        chk(1, "ackvec after reset", ack_vec, 8'h0F);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule